// File: doc/BRIEF.md
# Performance Event Combiner Counter

A 64-bit hardware performance counter whose per-cycle increment comes from up to four event sources picked out of a vector of event increment lanes. A 64-bit configuration word holds four 10-bit selectors, three 5-bit merge operators, five privilege-mode inhibit bits and a sticky overflow flag. Each cycle, the four selected lane values are merged as a two-level tree. The first operator merges selectors 0 and 1. The second merges selectors 2 and 3. The third merges the two partial results. If the hart's current mode is not inhibited, the result is added to the counter.

Both the configuration word and the counter have a plain write port (enable plus data) and a read port that always shows the register. The event lanes, mode and inhibit pins are sampled on every clock edge. They carry no handshake, so there is no back-pressure: a value missed in a cycle is lost. Both registers take their new value on the clock edge after a write or an increment. The read ports show it from then on.

Top module: `perf_combiner_counter`

## Requirements
- R1: After reset both the configuration word and the counter read zero, so every operator field holds the OR code.
- R2: Selector k sits at configuration bits [10k+9:10k] (k = 0..3). A selector value s in 1..NUM_EVENTS picks event lane s-1. A value of 0, or any value above NUM_EVENTS, contributes zero.
- R3: Operator codes are OR=0, AND=1, XOR=2 and ADD=4. They sit at bits [44:40] (merges selectors 0 and 1), [49:45] (merges selectors 2 and 3) and [54:50] (merges the two partial results). Values are merged at the lane width plus two bits.
- R4: A configuration write whose operator field holds any code other than 0, 1, 2 or 4 leaves that field unchanged. The other fields still take the written data. Bits [57:55] always read zero.
- R5: Bits 62, 61, 60, 59 and 58 block counting in M, S, U, VS and VU mode. The mode encoding is priv 3 = M, 1 = S and 0 = U, with virt = 1 turning S into VS and U into VU. virt is ignored in M.
- R6: While the global inhibit input is high, the counter does not advance.
- R7: When not inhibited, the counter adds the full merged value in one cycle, so it may step by more than one. A merged value of zero leaves it unchanged.
- R8: A counter write in the same cycle as an increment wins. The counter takes the written value.
- R9: When a hardware increment carries out of bit 63, the counter wraps and bit 63 of the configuration word becomes 1. It stays 1 until software writes it.
- R10: A configuration write sets bit 63 to the written bit, even in a cycle where a hardware carry occurs.
- R11: A software write to the counter, even of the all-ones value, never sets the overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Write configuration word this cycle |
| cfg_wr_data | input | 64 | Configuration write data |
| cfg_rd_data | output | 64 | Current configuration word |
| cnt_wr_en | input | 1 | Write counter this cycle |
| cnt_wr_data | input | 64 | Counter write data |
| cnt_rd_data | output | 64 | Current counter value |
| evt_values | input | NUM_EVENTS*EVT_W | Per-cycle event increment lanes, lane i at [i*EVT_W +: EVT_W] |
| priv_mode | input | 2 | Current privilege: 3 = M, 1 = S, 0 = U |
| virt_mode | input | 1 | Virtualized mode flag |
| inhibit_all | input | 1 | Global counting inhibit |

## Verification
The bench drives each operator code at both tree levels. A design that swapped the tree pairing, or truncated the adder, would produce the wrong increments. It sets each privilege inhibit bit and runs in the matching mode and in a different one. A mis-mapped bit would block the wrong mode or none. It writes illegal operator codes next to legal field changes. A design without legality filtering would load the illegal code, and one that filtered too much would drop the selector change. It drives the counter across its 64-bit limit, races a configuration write against that carry, writes the all-ones value, and writes the counter during an increment. A design that got priority or stickiness wrong would lose the flag, raise it on a write, or leave a count that is off by the increment.

// File: rtl/perf_comb_pkg.sv
package perf_comb_pkg;

  localparam int CFG_W   = 64;
  localparam int SEL_W   = 10;
  localparam int OP_W    = 5;
  localparam int NUM_SEL = 4;
  localparam int NUM_OP  = 3;
  localparam int OP_LSB  = 40;
  localparam int OVF_BIT = 63;
  localparam int INH_LSB = 58;
  localparam int INH_W   = 5;

  // bits 57:55 are reserved and read zero
  localparam logic [CFG_W-1:0] CFG_KEEP = ~(64'h7 << 55);

  typedef enum logic [OP_W-1:0] {
    MERGE_OR  = 5'd0,
    MERGE_AND = 5'd1,
    MERGE_XOR = 5'd2,
    MERGE_ADD = 5'd4
  } merge_op_e;

  typedef enum logic [1:0] {
    PRIV_U = 2'd0,
    PRIV_S = 2'd1,
    PRIV_M = 2'd3
  } priv_e;

  function automatic logic op_is_legal(input logic [OP_W-1:0] code);
    return (code == MERGE_OR) || (code == MERGE_AND) ||
           (code == MERGE_XOR) || (code == MERGE_ADD);
  endfunction

endpackage

// File: rtl/perf_evt_select.sv
module perf_evt_select #(
  parameter int NUM_EVENTS = 8,
  parameter int EVT_W      = 6,
  parameter int SEL_W      = 10
) (
  input  logic [SEL_W-1:0]            sel,
  input  logic [NUM_EVENTS*EVT_W-1:0] lanes,
  output logic [EVT_W-1:0]            value
);

  // selector 0 and out-of-range selectors yield zero; s picks lane s-1
  always_comb begin
    value = '0;
    for (int i = 0; i < NUM_EVENTS; i++) begin
      if (sel == SEL_W'(i + 1)) value = lanes[i*EVT_W +: EVT_W];
    end
  end

endmodule

// File: rtl/perf_evt_merge.sv
module perf_evt_merge
  import perf_comb_pkg::*;
#(
  parameter int VAL_W = 8
) (
  input  logic [VAL_W-1:0] a,
  input  logic [VAL_W-1:0] b,
  input  logic [OP_W-1:0]  op,
  output logic [VAL_W-1:0] y
);

  always_comb begin
    unique case (op)
      MERGE_AND: y = a & b;
      MERGE_XOR: y = a ^ b;
      MERGE_ADD: y = a + b;
      MERGE_OR:  y = a | b;
      default:   y = '0;
    endcase
  end

endmodule

// File: rtl/perf_mode_filter.sv
module perf_mode_filter
  import perf_comb_pkg::*;
(
  input  logic [1:0]       priv_mode,
  input  logic             virt_mode,
  input  logic [INH_W-1:0] inh_bits,   // [4]=M [3]=S [2]=U [1]=VS [0]=VU
  input  logic             inhibit_all,
  output logic             count_ok
);

  logic blocked;

  always_comb begin
    case (priv_mode)
      PRIV_M:  blocked = inh_bits[4];
      PRIV_S:  blocked = virt_mode ? inh_bits[1] : inh_bits[3];
      PRIV_U:  blocked = virt_mode ? inh_bits[0] : inh_bits[2];
      default: blocked = 1'b0;
    endcase
    count_ok = !inhibit_all && !blocked;
  end

endmodule

// File: rtl/perf_cfg_reg.sv
module perf_cfg_reg
  import perf_comb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  input  logic             hw_ovf,
  output logic [CFG_W-1:0] cfg_q
);

  logic [CFG_W-1:0] cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) begin
      cfg_d = wr_data & CFG_KEEP;
      for (int k = 0; k < NUM_OP; k++) begin
        if (!op_is_legal(wr_data[OP_LSB + k*OP_W +: OP_W]))
          cfg_d[OP_LSB + k*OP_W +: OP_W] = cfg_q[OP_LSB + k*OP_W +: OP_W];
      end
    end else if (hw_ovf) begin
      cfg_d[OVF_BIT] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  for (genvar k = 0; k < NUM_OP; k++) begin : g_op_chk
    a_r4_illegal_op_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !op_is_legal(wr_data[OP_LSB + k*OP_W +: OP_W])) |=>
      (cfg_q[OP_LSB + k*OP_W +: OP_W] == $past(cfg_q[OP_LSB + k*OP_W +: OP_W])));
  end

  a_r9_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[OVF_BIT] && !wr_en) |=> cfg_q[OVF_BIT]);

  a_r10_write_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (cfg_q[OVF_BIT] == $past(wr_data[OVF_BIT])));

endmodule

// File: rtl/perf_combiner_counter.sv
module perf_combiner_counter
  import perf_comb_pkg::*;
#(
  parameter int NUM_EVENTS = 8,
  parameter int EVT_W      = 6,
  parameter int CNT_W      = 64
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_wr_en,
  input  logic [CFG_W-1:0]            cfg_wr_data,
  output logic [CFG_W-1:0]            cfg_rd_data,
  input  logic                        cnt_wr_en,
  input  logic [CNT_W-1:0]            cnt_wr_data,
  output logic [CNT_W-1:0]            cnt_rd_data,
  input  logic [NUM_EVENTS*EVT_W-1:0] evt_values,
  input  logic [1:0]                  priv_mode,
  input  logic                        virt_mode,
  input  logic                        inhibit_all
);

  localparam int RES_W = EVT_W + 2;

  logic [CFG_W-1:0] cfg_q;
  logic [CNT_W-1:0] cnt_q;
  logic [EVT_W-1:0] picked [NUM_SEL];
  logic [RES_W-1:0] partial [2];
  logic [RES_W-1:0] incr;
  logic             count_ok;
  logic             advance;
  logic [CNT_W:0]   sum;
  logic             hw_ovf;

  for (genvar g = 0; g < NUM_SEL; g++) begin : g_sel
    perf_evt_select #(.NUM_EVENTS(NUM_EVENTS), .EVT_W(EVT_W), .SEL_W(SEL_W)) u_sel (
      .sel   (cfg_q[g*SEL_W +: SEL_W]),
      .lanes (evt_values),
      .value (picked[g])
    );
  end

  for (genvar p = 0; p < 2; p++) begin : g_pair
    perf_evt_merge #(.VAL_W(RES_W)) u_pair (
      .a  (RES_W'(picked[2*p])),
      .b  (RES_W'(picked[2*p+1])),
      .op (cfg_q[OP_LSB + p*OP_W +: OP_W]),
      .y  (partial[p])
    );
  end

  perf_evt_merge #(.VAL_W(RES_W)) u_root (
    .a  (partial[0]),
    .b  (partial[1]),
    .op (cfg_q[OP_LSB + 2*OP_W +: OP_W]),
    .y  (incr)
  );

  perf_mode_filter u_filter (
    .priv_mode   (priv_mode),
    .virt_mode   (virt_mode),
    .inh_bits    (cfg_q[INH_LSB +: INH_W]),
    .inhibit_all (inhibit_all),
    .count_ok    (count_ok)
  );

  assign advance = count_ok && (incr != '0);
  assign sum     = {1'b0, cnt_q} + (CNT_W + 1)'(incr);
  assign hw_ovf  = advance && !cnt_wr_en && sum[CNT_W];

  perf_cfg_reg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr_en),
    .wr_data (cfg_wr_data),
    .hw_ovf  (hw_ovf),
    .cfg_q   (cfg_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (cnt_wr_en) cnt_q <= cnt_wr_data;
    else if (advance)   cnt_q <= sum[CNT_W-1:0];
  end

  assign cfg_rd_data = cfg_q;
  assign cnt_rd_data = cnt_q;

  a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr_en |=> (cnt_q == $past(cnt_wr_data)));

  a_r6_global_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (inhibit_all && !cnt_wr_en) |=> $stable(cnt_q));

  a_r7_zero_incr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (incr == '0 && !cnt_wr_en) |=> $stable(cnt_q));

  a_r11_write_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wr_en && !cfg_wr_en && !cfg_q[OVF_BIT]) |=> !cfg_q[OVF_BIT]);

endmodule

// File: tb/test_perf_combiner_counter.sv
module test_perf_combiner_counter;

  localparam int NE = 8;
  localparam int EW = 6;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           cfg_wr_en = 1'b0;
  logic [63:0]    cfg_wr_data = '0;
  logic [63:0]    cfg_rd_data;
  logic           cnt_wr_en = 1'b0;
  logic [63:0]    cnt_wr_data = '0;
  logic [63:0]    cnt_rd_data;
  logic [NE*EW-1:0] evt_values = '0;
  logic [1:0]     priv_mode = 2'd3;
  logic           virt_mode = 1'b0;
  logic           inhibit_all = 1'b0;

  always #2.5 clk = ~clk;

  perf_combiner_counter #(.NUM_EVENTS(NE), .EVT_W(EW), .CNT_W(64)) i_perf_combiner_counter (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data), .cfg_rd_data(cfg_rd_data),
    .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data), .cnt_rd_data(cnt_rd_data),
    .evt_values(evt_values), .priv_mode(priv_mode), .virt_mode(virt_mode),
    .inhibit_all(inhibit_all)
  );

  typedef struct {
    logic [63:0] cnt;
    logic [63:0] cfg;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          errors = 0;
  int          checks = 0;
  bit          done = 0;
  logic [63:0] m_cfg = '0;
  logic [63:0] m_cnt = '0;
  int          ev[NE];

  function automatic logic [63:0] mk(int s0, int s1, int s2, int s3,
                                     int o0, int o1, int o2, int inh, int ovf);
    logic [63:0] v = '0;
    v[9:0]   = 10'(s0);
    v[19:10] = 10'(s1);
    v[29:20] = 10'(s2);
    v[39:30] = 10'(s3);
    v[44:40] = 5'(o0);
    v[49:45] = 5'(o1);
    v[54:50] = 5'(o2);
    v[62:58] = 5'(inh);
    v[63]    = 1'(ovf);
    return v;
  endfunction

  function automatic logic [7:0] pick(logic [9:0] s);
    if (s == 0 || s > NE) return 8'd0;
    return 8'(ev[s-1]);
  endfunction

  function automatic logic [7:0] mop(logic [7:0] a, logic [7:0] b, logic [4:0] c);
    case (c)
      5'd0: return a | b;
      5'd1: return a & b;
      5'd2: return a ^ b;
      5'd4: return a + b;
      default: return 8'd0;
    endcase
  endfunction

  function automatic bit legal(logic [4:0] c);
    return c == 0 || c == 1 || c == 2 || c == 4;
  endfunction

  task automatic step(input logic cw, input logic [63:0] cwd,
                      input logic nw, input logic [63:0] nwd,
                      input logic [1:0] pm, input logic vm, input logic gi,
                      input string tag);
    logic [7:0]  inc;
    logic        blk;
    logic [64:0] sum;
    logic        go;
    logic [63:0] ncfg;
    logic [63:0] ncnt;
    exp_t        e;
    @(negedge clk);
    cfg_wr_en = cw; cfg_wr_data = cwd;
    cnt_wr_en = nw; cnt_wr_data = nwd;
    priv_mode = pm; virt_mode = vm; inhibit_all = gi;
    for (int i = 0; i < NE; i++) evt_values[i*EW +: EW] = EW'(ev[i]);
    inc = mop(mop(pick(m_cfg[9:0]), pick(m_cfg[19:10]), m_cfg[44:40]),
              mop(pick(m_cfg[29:20]), pick(m_cfg[39:30]), m_cfg[49:45]),
              m_cfg[54:50]);
    case (pm)
      2'd3: blk = m_cfg[62];
      2'd1: blk = vm ? m_cfg[59] : m_cfg[61];
      2'd0: blk = vm ? m_cfg[58] : m_cfg[60];
      default: blk = 1'b0;
    endcase
    go  = !gi && !blk && inc != 0;
    sum = {1'b0, m_cnt} + 65'(inc);
    ncnt = nw ? nwd : (go ? sum[63:0] : m_cnt);
    ncfg = m_cfg;
    if (cw) begin
      ncfg = cwd;
      ncfg[57:55] = 3'b000;
      for (int k = 0; k < 3; k++)
        if (!legal(cwd[40+5*k +: 5])) ncfg[40+5*k +: 5] = m_cfg[40+5*k +: 5];
    end else if (go && !nw && sum[64]) begin
      ncfg[63] = 1'b1;
    end
    e.cnt = ncnt; e.cfg = ncfg; e.tag = tag;
    sb.push_back(e);
    m_cnt = ncnt; m_cfg = ncfg;
  endtask

  task automatic idle(input logic [1:0] pm, input logic vm, input string tag);
    step(1'b0, '0, 1'b0, '0, pm, vm, 1'b0, tag);
  endtask

  task automatic wcfg(input logic [63:0] v, input string tag);
    step(1'b1, v, 1'b0, '0, 2'd3, 1'b0, 1'b0, tag);
  endtask

  task automatic wcnt(input logic [63:0] v, input string tag);
    step(1'b0, '0, 1'b1, v, 2'd3, 1'b0, 1'b0, tag);
  endtask

  // monitor: compares after every edge that has a pending expectation
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (cnt_rd_data !== e.cnt) begin
          errors++;
          $display("FAIL %s counter actual=%h expected=%h", e.tag, cnt_rd_data, e.cnt);
        end
        checks++;
        if (cfg_rd_data !== e.cfg) begin
          errors++;
          $display("FAIL %s config actual=%h expected=%h", e.tag, cfg_rd_data, e.cfg);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all) actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NE; i++) ev[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    checks++;
    if (cfg_rd_data !== 64'd0 || cnt_rd_data !== 64'd0) begin
      errors++;
      $display("FAIL R1 reset actual=%h/%h expected=0/0", cfg_rd_data, cnt_rd_data);
    end
    rst_n = 1'b1;

    // R3: OR at first level
    ev[0] = 5; ev[1] = 3; ev[2] = 12; ev[3] = 10; ev[7] = 9;
    wcfg(mk(1, 2, 0, 0, 0, 0, 0, 0, 0), "R3 cfg");
    repeat (3) idle(2'd3, 1'b0, "R3 OR");
    // R3: AND, XOR
    wcfg(mk(1, 2, 0, 0, 1, 0, 0, 0, 0), "R3 cfg AND");
    repeat (2) idle(2'd3, 1'b0, "R3 AND");
    wcfg(mk(1, 2, 0, 0, 2, 0, 0, 0, 0), "R3 cfg XOR");
    repeat (2) idle(2'd3, 1'b0, "R3 XOR");
    // R3/R7: ADD tree, multi-step increment
    ev[0] = 60; ev[1] = 61; ev[2] = 62; ev[3] = 63;
    wcfg(mk(1, 2, 3, 4, 4, 4, 4, 0, 0), "R7 cfg ADD");
    repeat (2) idle(2'd3, 1'b0, "R7 ADD tree");
    wcfg(mk(1, 2, 3, 4, 4, 4, 2, 0, 0), "R3 cfg root XOR");
    repeat (2) idle(2'd3, 1'b0, "R3 root XOR");
    wcfg(mk(3, 4, 1, 2, 0, 1, 1, 0, 0), "R3 cfg pairs");
    repeat (2) idle(2'd3, 1'b0, "R3 pair AND");
    // R2: lane mapping and out-of-range selectors
    wcfg(mk(8, 0, 0, 0, 0, 0, 0, 0, 0), "R2 cfg lane8");
    repeat (2) idle(2'd3, 1'b0, "R2 top lane");
    wcfg(mk(9, 1023, 0, 0, 4, 4, 4, 0, 0), "R2 cfg out of range");
    repeat (2) idle(2'd3, 1'b0, "R2 out of range");
    // R4: illegal operator writes keep the field, other fields update
    wcfg(mk(1, 2, 3, 4, 4, 1, 2, 0, 0), "R4 legal base");
    wcfg(mk(2, 3, 4, 5, 3, 5, 31, 0, 0), "R4 illegal ops");
    wcfg(mk(1, 1, 0, 0, 7, 0, 8, 0, 0) | (64'h7 << 55), "R4 mixed and reserved");
    idle(2'd3, 1'b0, "R4 after illegal");
    // R5: each inhibit bit blocks its own mode only
    for (int m = 0; m < 5; m++) begin
      logic [1:0] pm;
      logic       vm;
      pm = (m == 0) ? 2'd3 : (m == 1 || m == 3) ? 2'd1 : 2'd0;
      vm = (m >= 3);
      wcfg(mk(1, 0, 0, 0, 0, 0, 0, 1 << (4 - m), 0), "R5 cfg inhibit");
      idle(pm, vm, "R5 blocked mode");
      idle(pm == 2'd3 ? 2'd1 : 2'd3, 1'b0, "R5 other mode");
      idle(pm, ~vm, "R5 virt flipped");
    end
    // R6: global inhibit
    wcfg(mk(1, 2, 0, 0, 4, 0, 0, 0, 0), "R6 cfg");
    step(1'b0, '0, 1'b0, '0, 2'd3, 1'b0, 1'b1, "R6 global inhibit");
    step(1'b0, '0, 1'b0, '0, 2'd0, 1'b1, 1'b1, "R6 global inhibit VU");
    // R7: zero merged value
    ev[0] = 0; ev[1] = 0;
    repeat (2) idle(2'd3, 1'b0, "R7 zero increment");
    ev[0] = 5; ev[1] = 3;
    // R8: write beats increment
    step(1'b0, '0, 1'b1, 64'h1234_5678_9abc_def0, 2'd3, 1'b0, 1'b0, "R8 write wins");
    idle(2'd3, 1'b0, "R8 after write");
    // R9: wrap and sticky flag
    wcnt(64'hFFFF_FFFF_FFFF_FFFD, "R9 preload");
    idle(2'd3, 1'b0, "R9 wrap");
    repeat (3) idle(2'd3, 1'b0, "R9 sticky");
    // R10: config write clears flag even during a carry
    wcfg(mk(1, 2, 0, 0, 4, 0, 0, 0, 0), "R10 clear flag");
    wcnt(64'hFFFF_FFFF_FFFF_FFFF, "R11 all ones write");
    wcfg(mk(1, 2, 0, 0, 4, 0, 0, 0, 0), "R10 write during carry");
    idle(2'd3, 1'b0, "R10 after");
    wcfg(mk(1, 2, 0, 0, 4, 0, 0, 0, 1), "R10 software set");
    wcfg(mk(1, 2, 0, 0, 4, 0, 0, 0, 0), "R10 software clear");
    // R11: counter writes never raise the flag
    step(1'b0, '0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 1'b0, 1'b1, "R11 write max");
    step(1'b0, '0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFE, 2'd3, 1'b0, 1'b0, "R11 write during carry");
    idle(2'd3, 1'b0, "R9 carry after write");

    step(1'b0, '0, 1'b0, '0, 2'd3, 1'b0, 1'b1, "R6 final hold");
    repeat (3) @(posedge clk);
    #2;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule